// File: doc/BRIEF.md
# Serial PCM Audio Receiver with Bit-Clock Recovery

This block takes stereo PCM audio from a three-wire serial link: a channel-select/frame clock, a bit clock and a data line. All three are sampled in the master-clock domain. The master clock must run at 256, 384 or 512 times the frame rate. The block finds that ratio by counting master-clock cycles over each frame. It declares lock once the ratio is legal and repeats on consecutive frames. It then presents one left/right pair of 24-bit words with a single-cycle strobe at the end of every frame.

The bit clock comes from one of two sources. A transmitter can drive the bit clock, at up to 128 bit periods per frame, and data are taken on its rising edges. If the bit-clock input is tied low, the block generates its own bit timing from the master clock at 64 bit periods per frame. This divides the master clock by 4, 6 or 8 to match the detected ratio. The block picks the source frame by frame from whether the bit-clock input rose during the previous frame. Words are MSB first and left-justified in each half-frame.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset the strobe is low and both output words are zero.
- R2: A frame runs from one rising edge of the frame clock to the next. Its length in master-clock cycles is legal when it is 256, 384 or 512. The first strobe comes at the end of the third complete frame after reset, when three consecutive frames have the same legal length.
- R3: In internal timing, with ratio R and D = R/64, bit k of a half-frame is sampled in master-clock cycle k·D + D/2 counted from the cycle that first shows the new frame-clock level. That cycle is numbered 0.
- R4: When the bit-clock input rose at least once in the previous frame, data are sampled on each rising edge of the bit-clock input in the master-clock domain.
- R5: Each word is taken MSB first, starting at the frame-clock edge. The half-frame with the frame clock high gives the left word. The half-frame with it low gives the right word.
- R6: Bits after the 24th in a half-frame have no effect on the output word.
- R7: When fewer than 24 bits arrive in a half-frame, the missing low-order bits of the word are zero.
- R8: The strobe lasts one cycle. It rises in the cycle after the master clock first samples the frame clock high, and it reports the frame that just ended. The output words change only together with the strobe.
- R9: A frame length other than 256, 384 or 512 produces no strobe.
- R10: After the frame length changes, there is no strobe until three consecutive frames have the new legal length. The internal bit timing then follows the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 256/384/512 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock; high selects the left channel |
| bck_in | input | 1 | External bit clock; tie low to select internal timing |
| sdata | input | 1 | Serial audio data |
| left_word | output | 24 | Left sample of the last completed frame |
| right_word | output | 24 | Right sample of the last completed frame |
| word_strobe | output | 1 | One-cycle pulse when a new word pair is presented |

## Verification
The hardest state to reach is a lock change without a reset: the internal bit timing must switch divisor after the frame length moves from one legal ratio to another. For a few frames the divisor is stale and the captured bits are garbage. The stimulus runs locked frames at 384, then switches straight to 512. The reference model, which tracks frame lengths on its own, expects exactly two silent frame ends before the first strobe and then checks the data against the new timing. Illegal frame lengths and external bit clocks that send more or fewer than 24 bits per half-frame are also driven.

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 11,
  parameter int BIT_W  = 6
)(
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              lrck,
  input  logic              bck_in,
  input  logic              sdata,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word,
  output logic              word_strobe
);
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] RATIO_LO  = CNT_W'(4 * FRAME_BITS);
  localparam logic [CNT_W-1:0] RATIO_MID = CNT_W'(6 * FRAME_BITS);
  localparam logic [CNT_W-1:0] RATIO_HI  = CNT_W'(8 * FRAME_BITS);

  logic              lr_q, bk_q, started, locked, seen, ext;
  logic [CNT_W-1:0]  cnt, prev_cnt;
  logic [3:0]        div, ph;
  logic [BIT_W-1:0]  bitn;
  logic [WORD_W-1:0] shreg, left_hold;

  logic lr_edge, lr_rise, bk_rise, legal, new_lock, ph_last, cap;
  logic [3:0]        div_next;
  logic [IDX_W-1:0]  wr_idx;
  logic [CNT_W-1:0]  cnt_inc;
  logic [BIT_W-1:0]  bitn_inc;

  assign lr_edge  = lrck ^ lr_q;
  assign lr_rise  = lrck & ~lr_q;
  assign bk_rise  = bck_in & ~bk_q;
  assign legal    = (cnt == RATIO_LO) || (cnt == RATIO_MID) || (cnt == RATIO_HI);
  assign new_lock = started && legal && (cnt == prev_cnt);
  assign div_next = 4'(cnt >> $clog2(FRAME_BITS));
  assign ph_last  = (ph == div - 4'd1);
  assign cap      = !lr_edge && (bitn < BIT_W'(WORD_W)) &&
                    (ext ? bk_rise : (ph == (div >> 1)));
  assign wr_idx   = IDX_W'(WORD_W - 1 - int'(bitn));
  assign cnt_inc  = cnt + CNT_W'(cnt != '1);
  assign bitn_inc = bitn + BIT_W'(bitn != '1);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q        <= 1'b0;
      bk_q        <= 1'b0;
      started     <= 1'b0;
      locked      <= 1'b0;
      seen        <= 1'b0;
      ext         <= 1'b0;
      cnt         <= '0;
      prev_cnt    <= '0;
      div         <= 4'd8;
      ph          <= '0;
      bitn        <= '0;
      shreg       <= '0;
      left_hold   <= '0;
      left_word   <= '0;
      right_word  <= '0;
      word_strobe <= 1'b0;
    end else begin
      lr_q        <= lrck;
      bk_q        <= bck_in;
      word_strobe <= 1'b0;

      if (lr_edge) begin
        ph    <= 4'd1;
        bitn  <= '0;
        shreg <= '0;
        if (lr_q) left_hold <= shreg;
      end else begin
        ph <= ph_last ? 4'd0 : ph + 4'd1;
        if (ext ? cap : ph_last) bitn <= bitn_inc;
        if (cap) shreg[wr_idx] <= sdata;
      end

      if (lr_rise) begin
        started  <= 1'b1;
        prev_cnt <= started ? cnt : '0;
        locked   <= new_lock;
        if (new_lock) div <= div_next;
        ext      <= seen;
        seen     <= 1'b0;
        cnt      <= CNT_W'(1);
        if (locked && new_lock) begin
          left_word   <= left_hold;
          right_word  <= shreg;
          word_strobe <= 1'b1;
        end
      end else begin
        cnt <= cnt_inc;
        if (bk_rise) seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 11
)(
  input logic              mclk,
  input logic              rst_n,
  input logic              lrck,
  input logic              word_strobe,
  input logic [WORD_W-1:0] left_word,
  input logic [WORD_W-1:0] right_word,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  prev_cnt,
  input logic [3:0]        div,
  input logic              locked
);
  // R8
  strobe_pulse_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    word_strobe |=> !word_strobe);

  // R8
  words_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !word_strobe |-> ($stable(left_word) && $stable(right_word)));

  // R8
  strobe_after_rise_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    word_strobe |-> ($past(lrck) && !$past(lrck, 2)));

  // R9
  legal_ratio_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    word_strobe |-> ($past(cnt) == CNT_W'(256) || $past(cnt) == CNT_W'(384) ||
                     $past(cnt) == CNT_W'(512)));

  // R10
  div_match_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |-> (prev_cnt == CNT_W'({div, 6'b0})));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .lrck(lrck), .word_strobe(word_strobe),
  .left_word(left_word), .right_word(right_word), .cnt(cnt),
  .prev_cnt(prev_cnt), .div(div), .locked(locked)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0, bck_in = 1'b0, sdata = 1'b0;
  logic [23:0] left_word, right_word;
  logic word_strobe;

  always #10 mclk = ~mclk;

  pcm_serial_rx u_dut (
    .mclk(mclk), .rst_n(rst_n), .lrck(lrck), .bck_in(bck_in), .sdata(sdata),
    .left_word(left_word), .right_word(right_word), .word_strobe(word_strobe)
  );

  int nchk = 0, nbad = 0;
  bit done = 1'b0;
  string data_req = "R2";

  bit          exp_v = 1'b0;
  logic [23:0] exp_l = '0, exp_r = '0;
  logic [23:0] frame_l = '0, frame_r = '0;
  bit          started = 1'b0;
  int          since_rise = 0;
  int          per_q[$];

  function automatic bit legal_len(int p);
    return (p == 256) || (p == 384) || (p == 512);
  endfunction

  task automatic fail(string req, string what, logic [47:0] act, logic [47:0] exp);
    nbad++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic drive(logic lr, logic bk, logic sd, bit rise);
    @(negedge mclk);
    nchk++;
    if (word_strobe !== exp_v)
      fail(exp_v ? data_req : "R8", "strobe", {47'd0, word_strobe}, {47'd0, exp_v});
    nchk++;
    if (left_word !== exp_l || right_word !== exp_r)
      fail(exp_v ? data_req : "R8", "words", {left_word, right_word}, {exp_l, exp_r});
    lrck = lr; bck_in = bk; sdata = sd;
    exp_v = 1'b0;
    if (rise) begin
      if (started) begin
        per_q.push_back(since_rise);
        if (per_q.size() > 3) void'(per_q.pop_front());
        if (per_q.size() == 3 && per_q[0] == per_q[1] && per_q[1] == per_q[2] &&
            legal_len(per_q[2])) begin
          exp_v = 1'b1; exp_l = frame_l; exp_r = frame_r;
        end
      end
      started = 1'b1;
      since_rise = 1;
    end else begin
      since_rise++;
    end
  endtask

  task automatic do_reset();
    @(negedge mclk);
    rst_n = 1'b0; lrck = 1'b0; bck_in = 1'b0; sdata = 1'b0;
    exp_v = 1'b0; exp_l = '0; exp_r = '0; started = 1'b0; since_rise = 0;
    per_q.delete();
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
  endtask

  // ext=0: internal timing, 32 bits per half; ext=1: nbits per half on bck_in
  task automatic run_frame(int ratio, bit ext, int nbits);
    logic [63:0] w [2];
    logic [23:0] el, er, m;
    int h, t, d, k;
    w[0] = {$urandom, $urandom};
    w[1] = {$urandom, $urandom};
    h = ratio / 2;
    d = ratio / 64;
    t = ext ? h / nbits : 0;
    m = (ext && nbits < 24) ? ~(24'hFFFFFF >> nbits) : 24'hFFFFFF;
    el = w[0][63:40] & m;
    er = w[1][63:40] & m;
    for (int half = 0; half < 2; half++) begin
      for (int p = 0; p < h; p++) begin
        logic bk, sd;
        if (ext) begin
          k  = p / t;
          bk = (p % t) >= (t / 2);
          sd = w[half][63 - k];
        end else begin
          k  = p / d;
          bk = 1'b0;
          sd = (k < 32) ? w[half][63 - k] : 1'b0;
        end
        drive(half == 0, bk, sd, (half == 0) && (p == 0));
        if (half == 0 && p == 0) begin
          frame_l = el; frame_r = er;
        end
      end
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  initial begin
    do_reset();
    @(negedge mclk);
    // R1: reset state
    nchk++;
    if (word_strobe !== 1'b0 || left_word !== '0 || right_word !== '0)
      fail("R1", "reset outputs", {left_word, right_word}, 48'd0);

    // R2: internal timing at 256, first strobe after three equal frames
    data_req = "R2";
    repeat (7) run_frame(256, 1'b0, 32);

    // R10: switch 384 -> 512 without reset
    data_req = "R10";
    repeat (6) run_frame(384, 1'b0, 32);
    repeat (6) run_frame(512, 1'b0, 32);

    // R3/R5: internal timing at 512 from reset
    do_reset();
    data_req = "R3/R5";
    repeat (6) run_frame(512, 1'b0, 32);

    // R6: external bit clock, 64 bits per half
    do_reset();
    data_req = "R6";
    repeat (6) run_frame(256, 1'b1, 64);

    // R7: external bit clock, 16 bits per half
    do_reset();
    data_req = "R7";
    repeat (6) run_frame(512, 1'b1, 16);

    // R4: external bit clock, 24 bits per half
    do_reset();
    data_req = "R4";
    repeat (6) run_frame(384, 1'b1, 24);

    // R9: illegal frame length, never a strobe
    do_reset();
    data_req = "R9";
    repeat (6) run_frame(320, 1'b0, 32);

    drive(1'b1, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule